// File: doc/BRIEF.md
# Trigger-Committed Fractional Clock Divider

This block divides a source clock by a programmable divisor. The divisor has an integer part and a small number of fractional bits. Two stages sit in series. The first is an integer pre-divider that turns the source clock into a stream of enable pulses. The second is a fractional divider that counts those pulses and produces the output period marker `div_tick` and a divided clock `div_clk`. The fractional stage makes some periods one pre-divided cycle longer than others, and the long-run average matches the programmed fraction. The block accepts that period-to-period jitter.

Software writes each divisor into a bit field of a 32-bit register. The field holds the divisor minus one, and the offset of one applies to the integer bits above the fraction. A written value stays in a shadow copy until software sets the stage's commit bit. The commit bit reads back as 1 until the stage adopts the shadow value at its next period boundary, and then it clears by itself. The upstream clock gate drives `gate_en`. While `gate_en` is low both stages freeze. No boundary can occur, so a pending commit waits until the gate opens again.

Top module: `frac_clk_div`

## Requirements
- R1: Register map. Address 0 holds the fractional divisor field in data bits [15:8]. Address 1 holds the pre-divider field in bits [7:4]. Address 2 is the commit register: bit 0 commits the fractional stage and bit 1 commits the pre-divider. A read of address 0 or 1 returns the last written field in place, with every other bit zero. A read of address 2 returns the two pending flags in the same bit positions.
- R2: In the fractional field F, bits [1:0] are the fraction. With a fraction of zero and a pre-divider field of zero, `div_tick` pulses once every (F>>2)+1 source cycles.
- R3: With a fraction f = F[1:0], each output period lasts I or I+1 pre-divided cycles, where I = (F>>2)+1. Any four consecutive periods together last 4*I+f pre-divided cycles.
- R4: A commit of the fractional stage restarts its phase accumulator at zero. Each following period adds f to a 2-bit accumulator, and the period is one cycle longer exactly when that addition carries out.
- R5: Writes to address 0 or 1 change neither the output timing nor the active divisor until the matching commit bit is set.
- R6: Writing 1 to a commit bit makes it read 1. The fractional stage's bit returns to 0 in the same cycle that `div_tick` marks the boundary at which the new divisor starts. Writing 0 to a commit bit has no effect.
- R7: While `gate_en` is low, `div_tick` and `div_clk` stay low, the counters hold, and a pending commit bit stays 1. The commit completes only after `gate_en` returns high.
- R8: A pre-divider field P stretches every output period by a factor of P+1 source cycles. The pre-divider adopts a new field only through its own commit bit, bit 1.
- R9: After reset, addresses 0, 1 and 2 read 0, so both divisors are 1. `div_tick` and `div_clk` are low while `gate_en` is low.
- R10: `div_clk` is high whenever `div_tick` is high. In a period of L fractional-stage cycles with pre-divider factor Q, `div_clk` is high for Q*ceil(L/2) source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_en | input | 1 | Enable from the upstream clock gate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| div_clk | output | 1 | Divided clock, high for the first half of each period |
| div_tick | output | 1 | One-cycle pulse at each output period boundary |

## Verification
Three events can land in the same cycle: a fractional-stage period boundary, a pre-divider boundary, and the adoption of both pending divisors. The bench provokes this by committing both stages with a single write. It then requires that the fractional commit flag drops on exactly the sample where `div_tick` is high, and that the pre-divider flag has cleared by then. Every period that follows is compared against a model that multiplies the new pre-divider factor by the accumulator-driven fractional length. If the two stages loaded out of order, or the accumulator did not restart, at least one interval length or high-time count would differ from the model.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Register selector decoded from the 2-bit address.
  typedef enum logic [1:0] {
    REG_MAIN_DIV = 2'd0,
    REG_PRE_DIV  = 2'd1,
    REG_COMMIT   = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;

  // Bit positions inside the commit register.
  localparam int COMMIT_MAIN_BIT = 0;
  localparam int COMMIT_PRE_BIT  = 1;

endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
  import frac_div_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAIN_SHIFT = 8,
  parameter int MAIN_W     = 8,
  parameter int PRE_SHIFT  = 4,
  parameter int PRE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              main_done,
  input  logic              pre_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [MAIN_W-1:0] main_shadow,
  output logic [PRE_W-1:0]  pre_shadow,
  output logic              main_busy,
  output logic              pre_busy
);

  logic [MAIN_W-1:0] main_q, main_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              main_busy_q, main_busy_d;
  logic              pre_busy_q, pre_busy_d;
  logic              wr_data_unused;

  assign wr_data_unused = ^wr_data;

  // Next state: a completed load clears a flag, a fresh write of 1 sets it again.
  always_comb begin
    main_d      = main_q;
    pre_d       = pre_q;
    main_busy_d = main_busy_q & ~main_done;
    pre_busy_d  = pre_busy_q & ~pre_done;
    if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_MAIN_DIV: main_d = wr_data[MAIN_SHIFT +: MAIN_W];
        REG_PRE_DIV:  pre_d  = wr_data[PRE_SHIFT +: PRE_W];
        REG_COMMIT: begin
          if (wr_data[COMMIT_MAIN_BIT]) main_busy_d = 1'b1;
          if (wr_data[COMMIT_PRE_BIT])  pre_busy_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q      <= '0;
      pre_q       <= '0;
      main_busy_q <= 1'b0;
      pre_busy_q  <= 1'b0;
    end else begin
      main_q      <= main_d;
      pre_q       <= pre_d;
      main_busy_q <= main_busy_d;
      pre_busy_q  <= pre_busy_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_MAIN_DIV: rd_data[MAIN_SHIFT +: MAIN_W] = main_q;
      REG_PRE_DIV:  rd_data[PRE_SHIFT +: PRE_W]   = pre_q;
      REG_COMMIT: begin
        rd_data[COMMIT_MAIN_BIT] = main_busy_q;
        rd_data[COMMIT_PRE_BIT]  = pre_busy_q;
      end
      default: ;
    endcase
  end

  assign main_shadow = main_q;
  assign pre_shadow  = pre_q;
  assign main_busy   = main_busy_q;
  assign pre_busy    = pre_busy_q;

endmodule

// File: rtl/frac_div_stage.sv
module frac_div_stage #(
  parameter int FIELD_W = 8,
  parameter int FRAC_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   step,
  input  logic                   commit_req,
  input  logic [FIELD_W-1:0]     shadow,
  output logic                   tick,
  output logic                   commit_done,
  output logic [FIELD_W-1:0]     active,
  output logic [FIELD_W-FRAC_W:0] cnt_next,
  output logic [FIELD_W-FRAC_W:0] len_next
);

  localparam int INT_W = FIELD_W - FRAC_W;
  localparam int LEN_W = INT_W + 1;

  logic [FIELD_W-1:0] act_q, act_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic               boundary, load, carry;
  logic [FIELD_W-1:0] field_use;
  logic [LEN_W-1:0]   int_len;

  // A boundary is the last enabled cycle of the current period.
  assign boundary  = run & step & (cnt_q == (len_q - LEN_W'(1)));
  assign load      = boundary & commit_req;
  assign field_use = load ? shadow : act_q;
  // Stored value is divisor minus one; the one lands above the fraction.
  assign int_len   = LEN_W'(field_use[FIELD_W-1:FRAC_W]) + LEN_W'(1);

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W-1:0] acc_q, acc_d, acc_base;
      logic [FRAC_W:0]   acc_sum;

      always_comb begin
        acc_base = load ? '0 : acc_q;
        acc_sum  = {1'b0, acc_base} + {1'b0, field_use[FRAC_W-1:0]};
        acc_d    = boundary ? acc_sum[FRAC_W-1:0] : acc_q;
      end

      assign carry = acc_sum[FRAC_W];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
      end
    end else begin : g_int
      assign carry = 1'b0;
    end
  endgenerate

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    len_d = len_q;
    if (boundary) begin
      act_d = field_use;
      cnt_d = '0;
      len_d = int_len + LEN_W'(carry);
    end else if (run && step) begin
      cnt_d = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign tick        = boundary;
  assign commit_done = load;
  assign active      = act_q;
  assign cnt_next    = cnt_d;
  assign len_next    = len_d;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAIN_SHIFT = 8,
  parameter int MAIN_W     = 8,
  parameter int FRAC_W     = 2,
  parameter int PRE_SHIFT  = 4,
  parameter int PRE_W      = 4
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              div_clk,
  output logic              div_tick
);

  localparam int LEN_W     = MAIN_W - FRAC_W + 1;
  localparam int PRE_LEN_W = PRE_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic [MAIN_W-1:0] main_shadow, main_active;
  logic [PRE_W-1:0]  pre_shadow, pre_active;
  logic              main_busy, pre_busy, main_done, pre_done;
  logic              pre_tick, main_tick;
  logic [LEN_W-1:0]  m_cnt_n, m_len_n;
  logic [LEN_W:0]    m_half;
  logic [PRE_LEN_W-1:0] pre_cnt_unused, pre_len_unused;
  logic              clk_q, clk_d, tick_q, tick_d;

  // Reset asserts at once and releases two source edges later.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  frac_div_regs #(
    .DATA_W(DATA_W), .MAIN_SHIFT(MAIN_SHIFT), .MAIN_W(MAIN_W),
    .PRE_SHIFT(PRE_SHIFT), .PRE_W(PRE_W)
  ) u_regs (
    .clk(clk_src), .rst_n(rst_n_int),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .main_done(main_done), .pre_done(pre_done),
    .rd_data(rd_data), .main_shadow(main_shadow), .pre_shadow(pre_shadow),
    .main_busy(main_busy), .pre_busy(pre_busy)
  );

  frac_div_stage #(.FIELD_W(PRE_W), .FRAC_W(0)) u_pre (
    .clk(clk_src), .rst_n(rst_n_int),
    .run(gate_en), .step(1'b1), .commit_req(pre_busy), .shadow(pre_shadow),
    .tick(pre_tick), .commit_done(pre_done), .active(pre_active),
    .cnt_next(pre_cnt_unused), .len_next(pre_len_unused)
  );

  frac_div_stage #(.FIELD_W(MAIN_W), .FRAC_W(FRAC_W)) u_main (
    .clk(clk_src), .rst_n(rst_n_int),
    .run(gate_en), .step(pre_tick), .commit_req(main_busy), .shadow(main_shadow),
    .tick(main_tick), .commit_done(main_done), .active(main_active),
    .cnt_next(m_cnt_n), .len_next(m_len_n)
  );

  // High for the first ceil(len/2) counts of each fractional-stage period.
  assign m_half = ({1'b0, m_len_n} + (LEN_W+1)'(1)) >> 1;

  always_comb begin
    clk_d  = gate_en & ({1'b0, m_cnt_n} < m_half);
    tick_d = main_tick;
  end

  always_ff @(posedge clk_src or negedge rst_n_int) begin
    if (!rst_n_int) begin
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      clk_q  <= clk_d;
      tick_q <= tick_d;
    end
  end

  assign div_clk  = clk_q;
  assign div_tick = tick_q;

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int MAIN_W = 8,
  parameter int PRE_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              div_tick,
  input logic              div_clk,
  input logic              main_busy,
  input logic              pre_busy,
  input logic [MAIN_W-1:0] main_active,
  input logic [PRE_W-1:0]  pre_active
);

  assert_tick_needs_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(gate_en));

  assert_clk_low_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_en) |-> !div_clk);

  assert_pre_waits_for_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_busy) |-> $past(gate_en));

  assert_commit_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_busy) |-> div_tick);

  assert_main_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(main_busy) |-> $stable(main_active));

  assert_pre_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pre_busy) |-> $stable(pre_active));

  assert_clk_high_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> div_clk);

endmodule

bind frac_clk_div frac_clk_div_chk #(.MAIN_W(MAIN_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk_src), .rst_n(rst_n_int), .gate_en(gate_en),
  .div_tick(div_tick), .div_clk(div_clk),
  .main_busy(main_busy), .pre_busy(pre_busy),
  .main_active(main_active), .pre_active(pre_active)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;

  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;
  localparam int MAIN_SHIFT = 8;
  localparam int PRE_SHIFT = 4;

  logic        clk_src = 1'b0;
  logic        rst_n, gate_en, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        div_clk, div_tick;
  int checks = 0;
  int errors = 0;

  frac_clk_div uut (
    .clk_src(clk_src), .rst_n(rst_n), .gate_en(gate_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .div_clk(div_clk), .div_tick(div_tick)
  );

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_src); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk_src); #1;
    wr_en = 1'b0;
  endtask

  // Length of the next period in fractional-stage cycles (2 fraction bits).
  function automatic int next_len(input int field, inout int acc);
    int s;
    s = acc + (field & 3);
    acc = s % 4;
    return (field >> 2) + 1 + (s >= 4 ? 1 : 0);
  endfunction

  task automatic measure(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk_src);
      n++;
      if (div_clk) hi++;
    end while (!div_tick && n < 4000);
  endtask

  task automatic wait_commit(input int mask);
    int n = 0;
    rd_addr = 2'd2;
    do begin
      @(negedge clk_src);
      n++;
    end while ((rd_data & mask) != 0 && n < 5000);
    check(n < 5000, "R6", "commit flag never cleared", n, 0);
    if (mask == 1) begin
      check(div_tick == 1'b1, "R6", "tick at commit clear", div_tick, 1);
      check(rd_data[1] == 1'b0, "R8", "pre flag at main clear", rd_data[1], 0);
    end
  endtask

  task automatic run_seq(input int mf, input int q, input int count,
                         inout int acc, input string req);
    int n, hi, l, sum;
    sum = 0;
    for (int k = 0; k < count; k++) begin
      measure(n, hi);
      l = next_len(mf, acc);
      sum += n;
      check(n == q * l, req, "period length", n, q * l);
      check(hi == q * ((l + 1) / 2), "R10", "high time", hi, q * ((l + 1) / 2));
      if (k == 3)
        check(sum == q * (4 * ((mf >> 2) + 1) + (mf & 3)), "R3", "four-period sum",
              sum, q * (4 * ((mf >> 2) + 1) + (mf & 3)));
    end
  endtask

  task automatic program_div(input int mf, input int pf, input string req);
    int acc = 0;
    wr(2'd0, 32'(mf) << MAIN_SHIFT);
    wr(2'd1, 32'(pf) << PRE_SHIFT);
    wr(2'd2, 32'd3);
    wait_commit(1);
    run_seq(mf, pf + 1, 8, acc, req);
  endtask

  initial begin
    int acc, n, hi, sum, bad, mf, pf, lo_len;
    logic [31:0] d;
    rst_n = 1'b0; gate_en = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    void'($urandom(SEED));
    repeat (4) @(posedge clk_src);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk_src);
    // Reset state checks
    for (int a = 0; a < 3; a++) begin
      rd_addr = 2'(a); #1;
      check(rd_data == 32'd0, "R9", "reset register value", rd_data, 0);
    end
    @(negedge clk_src);
    check(div_tick == 1'b0, "R9", "tick while gated at reset", div_tick, 0);
    check(div_clk == 1'b0, "R9", "clock while gated at reset", div_clk, 0);

    // Register readback: field in place, other bits zero; writing 0 to the commit register does nothing
    @(posedge clk_src); #1;
    wr(2'd0, 32'hFFFF_FFFF);
    rd_addr = 2'd0; #1;
    check(rd_data == 32'h0000_FF00, "R1", "main field readback", rd_data, 32'h0000_FF00);
    wr(2'd1, 32'hA5A5_A5A5);
    rd_addr = 2'd1; #1;
    check(rd_data == 32'h0000_00A0, "R1", "pre field readback", rd_data, 32'h0000_00A0);
    wr(2'd2, 32'hFFFF_FFFC);
    rd_addr = 2'd2; #1;
    check(rd_data == 32'd0, "R6", "zero commit write ignored", rd_data, 0);

    gate_en = 1'b1;
    // Integer divisor, fraction zero
    program_div(20, 0, "R2");
    // Fractional divisor with a restart of the accumulator, with pre-divider
    program_div(9, 0, "R4");
    program_div(7, 2, "R8");

    // Uncommitted writes do not change timing
    program_div(13, 0, "R4");
    acc = 0;
    for (int k = 0; k < 8; k++) void'(next_len(13, acc));
    fork
      wr(2'd0, 32'(40) << MAIN_SHIFT);
    join_none
    run_seq(13, 1, 4, acc, "R5");
    rd_addr = 2'd0; #1;
    check(rd_data == (32'(40) << MAIN_SHIFT), "R1", "shadow holds new field", rd_data, 32'(40) << MAIN_SHIFT);

    // Gate closed: commit stays pending, outputs low
    @(posedge clk_src); #1;
    gate_en = 1'b0;
    wr(2'd2, 32'd1);
    bad = 0;
    rd_addr = 2'd2;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_src);
      if (rd_data[0] !== 1'b1 || div_tick !== 1'b0 || div_clk !== 1'b0) bad++;
    end
    check(bad == 0, "R7", "gated cycles with activity or lost commit", bad, 0);
    @(posedge clk_src); #1;
    gate_en = 1'b1;
    wait_commit(1);
    acc = 0;
    run_seq(40, 1, 4, acc, "R7");

    // Pre field committed only by its own bit
    wr(2'd1, 32'(3) << PRE_SHIFT);
    wr(2'd2, 32'd1);
    wait_commit(1);
    rd_addr = 2'd2; #1;
    check(rd_data[1] == 1'b0, "R8", "pre flag not set by main bit", rd_data[1], 0);
    acc = 0;
    run_seq(40, 1, 4, acc, "R8");
    wr(2'd2, 32'd2);
    wait_commit(2);
    measure(n, hi);
    sum = 0; bad = 0;
    lo_len = 4 * ((40 >> 2) + 1);
    for (int k = 0; k < 4; k++) begin
      measure(n, hi);
      sum += n;
      if (n != 4 * ((40 >> 2) + 1)) bad++;
    end
    check(bad == 0, "R8", "periods after pre commit off length", bad, 0);
    check(sum == 4 * lo_len, "R8", "sum after pre commit", sum, 4 * lo_len);

    // Random divisors
    for (int it = 0; it < 6; it++) begin
      mf = int'($urandom % 48);
      pf = int'($urandom % 3);
      program_div(mf, pf, "R4");
    end

    // Divisor of one in both stages: tick every cycle
    program_div(0, 0, "R2");

    d = 32'(checks);
    $display("CHECKS %0d ERRORS %0d", d, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_src);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule